// File: doc/BRIEF.md
# Translation-Overlapped Cache Lookup Unit

This unit resolves a 32-bit virtual load or store in a single cycle. It searches a small fully associative translation buffer for the virtual page number. In the same cycle it reads a 4 KB direct-mapped word cache. The cache can be indexed before translation finishes because its index and byte-select bits lie entirely inside the 12-bit page offset. The stored cache tag is then compared against the physical page number that the translation buffer returns.

A read whose page translates, whose rights allow the access, and whose cache line holds the matching physical tag returns its data at once. A read that translates but misses in the cache asks the memory side for the physical address. Writes are written through to memory. A write also updates the cached word when the line already holds that physical page, and it does not allocate a line on a miss.

Two cases never reach memory:
- A lookup that finds no translation raises a translation-miss flag so that a page walker elsewhere can take over.
- A lookup that the page's rights forbid raises a protection fault.

The unit also has a refill port, which writes whole translation entries into a round-robin victim slot, and a line-fill port for the memory side.

Top module: `vtlb_cache_lookup`

## Requirements
- R1: After reset every translation entry and every cache line is invalid, and the victim pointer is 0. Any lookup reports a translation miss, and the first refill lands in entry 0.
- R2: The virtual page number is address bits [31:12]. The cache line index is bits [11:2], which gives 1024 word lines, and bits [1:0] select a byte inside the word. Lines at index 0 and index 1023 are kept apart.
- R3: When a read translates (rights bit 0 set), its line is valid and the stored tag equals the physical page number, rsp_hit is 1 and rsp_data carries the word in the same cycle, and mem_req is 0.
- R4: When no valid entry matches the page number, tlb_miss is 1 and both mem_req and rsp_hit are 0.
- R5: When a permitted read translates but its line is invalid or holds another tag, mem_req is 1 and mem_we is 0. mem_paddr is the physical page number concatenated with address bits [11:0].
- R6: Rights bit 1 permits writes and rights bit 0 permits reads. A forbidden access raises prot_fault with mem_req and rsp_hit at 0. It leaves the cached word and the entry's referenced and dirty flags unchanged.
- R7: A permitted write always raises mem_req with mem_we 1 and mem_wdata equal to the write data. If its line hits, the cached word holds the new data from the next cycle on. A write that misses allocates no line.
- R8: On a translation hit, ent_ref and ent_dirty show the matched entry's flags. Every permitted access sets the referenced flag, and every permitted write also sets the dirty flag, both visible from the next lookup.
- R9: Each refill writes a whole valid entry into the slot named by a round-robin pointer that steps 0,1,...,7 and then wraps to 0. tlb_hit_idx reports the slot that matched.
- R10: When several valid entries hold the same page number, the lowest-numbered one supplies the translation.
- R11: A line fill writes the word at index fill_paddr[11:2], stores fill_paddr[31:12] as its tag and marks the line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| tlb_wr_en | input | 1 | Write one translation entry |
| tlb_wr_vpn | input | 20 | Virtual page number of the new entry |
| tlb_wr_ppn | input | 20 | Physical page number of the new entry |
| tlb_wr_rights | input | 2 | Access rights: bit 1 write, bit 0 read |
| tlb_wr_dirty | input | 1 | Initial dirty flag |
| tlb_wr_ref | input | 1 | Initial referenced flag |
| fill_en | input | 1 | Write one cache line |
| fill_paddr | input | 32 | Physical address of the filled word |
| fill_data | input | 32 | Filled word |
| rsp_hit | output | 1 | Data delivered from cache |
| rsp_data | output | 32 | Cached word (0 when no hit) |
| tlb_miss | output | 1 | No translation; full walk needed |
| prot_fault | output | 1 | Access forbidden by page rights |
| tlb_hit_idx | output | 3 | Slot that matched |
| ent_ref | output | 1 | Matched entry's referenced flag |
| ent_dirty | output | 1 | Matched entry's dirty flag |
| mem_req | output | 1 | Memory access required |
| mem_we | output | 1 | Memory access is a write |
| mem_paddr | output | 32 | Translated physical address |
| mem_wdata | output | 32 | Data for a memory write |

## Verification
A stale or wrong translation entry shows up in the cycle of the next lookup to that page. The symptoms are a wrong mem_paddr page, a wrong tlb_hit_idx, or a miss where a hit is due. Lost referenced or dirty updates, or a victim pointer that steps wrongly, appear one lookup later on ent_ref, ent_dirty and tlb_hit_idx. A corrupted cache word or tag is exposed by the next read of that index: it returns a wrong rsp_data, or it raises mem_req where a hit was due. This is why every write and fault scenario is followed at once by a read-back of the same address.

// File: rtl/lku_pkg.sv
package lku_pkg;
  localparam int VA_W       = 32;
  localparam int OFF_W      = 12;
  localparam int PN_W       = VA_W - OFF_W;
  localparam int BYTE_SEL_W = 2;
  localparam int LINE_IDX_W = OFF_W - BYTE_SEL_W;
  localparam int LINES      = 1 << LINE_IDX_W;
  localparam int WORD_W     = 32;
  localparam int RIGHTS_W   = 2;

  typedef struct packed {
    logic                valid;
    logic [PN_W-1:0]     vpn;
    logic [PN_W-1:0]     ppn;
    logic [RIGHTS_W-1:0] rights;
    logic                dirty;
    logic                refd;
  } xlat_entry_t;

  function automatic logic [PN_W-1:0] page_no(input logic [VA_W-1:0] a);
    return a[VA_W-1:OFF_W];
  endfunction

  function automatic logic [LINE_IDX_W-1:0] line_index(input logic [VA_W-1:0] a);
    return a[OFF_W-1:BYTE_SEL_W];
  endfunction

  function automatic logic [VA_W-1:0] phys_addr(input logic [PN_W-1:0] ppn,
                                                input logic [VA_W-1:0] va);
    return {ppn, va[OFF_W-1:0]};
  endfunction

  function automatic logic access_ok(input logic [RIGHTS_W-1:0] r, input logic wr);
    return wr ? r[1] : r[0];
  endfunction
endpackage

// File: rtl/lku_xlat_buf.sv
module lku_xlat_buf
  import lku_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PN_W-1:0]   lk_vpn,
  input  logic              upd_ref,
  input  logic              upd_dirty,
  input  logic              wr_en,
  input  xlat_entry_t       wr_entry,
  output logic              match_any,
  output logic [IW-1:0]     match_idx,
  output xlat_entry_t       match_entry,
  output logic [IW-1:0]     victim_ptr
);
  xlat_entry_t ent [N];
  logic [N-1:0] match_vec;
  logic [IW-1:0] ptr_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match_vec[g] = ent[g].valid && (ent[g].vpn == lk_vpn);
    end
  endgenerate

  // Lowest-numbered match wins: scan from the top so the last write is the lowest.
  always_comb begin
    match_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) match_idx = IW'(i);
    end
  end

  assign match_any   = |match_vec;
  assign match_entry = ent[match_idx];
  assign victim_ptr  = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent[i] <= '0;
      ptr_q <= '0;
    end else begin
      if (upd_ref && match_any)   ent[match_idx].refd  <= 1'b1;
      if (upd_dirty && match_any) ent[match_idx].dirty <= 1'b1;
      if (wr_en) begin
        ent[ptr_q] <= wr_entry;
        ptr_q      <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lku_line_store.sv
module lku_line_store
  import lku_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINE_IDX_W-1:0] rd_idx,
  output logic                  rd_valid,
  output logic [PN_W-1:0]       rd_tag,
  output logic [WORD_W-1:0]     rd_data,
  input  logic                  upd_en,
  input  logic [LINE_IDX_W-1:0] upd_idx,
  input  logic [WORD_W-1:0]     upd_data,
  input  logic                  fill_en,
  input  logic [LINE_IDX_W-1:0] fill_idx,
  input  logic [PN_W-1:0]       fill_tag,
  input  logic [WORD_W-1:0]     fill_data
);
  logic [LINES-1:0]  valid_q;
  logic [PN_W-1:0]   tag_q  [LINES];
  logic [WORD_W-1:0] data_q [LINES];

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  // A fill to the same index as a store hit takes precedence.
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      data_q[fill_idx] <= fill_data;
    end
    if (upd_en && !(fill_en && fill_idx == upd_idx)) data_q[upd_idx] <= upd_data;
  end
endmodule

// File: rtl/lku_decide.sv
module lku_decide
  import lku_pkg::*;
(
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                xl_hit,
  input  logic [RIGHTS_W-1:0] xl_rights,
  input  logic [PN_W-1:0]     xl_ppn,
  input  logic                line_valid,
  input  logic [PN_W-1:0]     line_tag,
  output logic                hit_o,
  output logic                miss_o,
  output logic                fault_o,
  output logic                mem_o,
  output logic                line_wr_o,
  output logic                ref_upd_o,
  output logic                dirty_upd_o
);
  logic allowed, tag_eq;

  assign allowed     = req_valid && xl_hit && access_ok(xl_rights, req_write);
  assign tag_eq      = line_valid && (line_tag == xl_ppn);
  assign miss_o      = req_valid && !xl_hit;
  assign fault_o     = req_valid && xl_hit && !access_ok(xl_rights, req_write);
  assign hit_o       = allowed && tag_eq;
  assign mem_o       = allowed && (req_write || !tag_eq);
  assign line_wr_o   = allowed && req_write && tag_eq;
  assign ref_upd_o   = allowed;
  assign dirty_upd_o = allowed && req_write;
endmodule

// File: rtl/vtlb_cache_lookup.sv
module vtlb_cache_lookup
  import lku_pkg::*;
#(
  parameter int TLB_ENTRIES = 8,
  localparam int TIW = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_vaddr,
  input  logic [31:0]       req_wdata,
  input  logic              tlb_wr_en,
  input  logic [19:0]       tlb_wr_vpn,
  input  logic [19:0]       tlb_wr_ppn,
  input  logic [1:0]        tlb_wr_rights,
  input  logic              tlb_wr_dirty,
  input  logic              tlb_wr_ref,
  input  logic              fill_en,
  input  logic [31:0]       fill_paddr,
  input  logic [31:0]       fill_data,
  output logic              rsp_hit,
  output logic [31:0]       rsp_data,
  output logic              tlb_miss,
  output logic              prot_fault,
  output logic [TIW-1:0]    tlb_hit_idx,
  output logic              ent_ref,
  output logic              ent_dirty,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_paddr,
  output logic [31:0]       mem_wdata
);
  xlat_entry_t  new_entry, hit_entry;
  logic         xl_hit;
  logic [TIW-1:0] xl_idx, rr_ptr;
  logic         line_valid;
  logic [PN_W-1:0]   line_tag;
  logic [WORD_W-1:0] line_data;
  logic         line_wr, ref_upd, dirty_upd;

  assign new_entry = '{valid: 1'b1, vpn: tlb_wr_vpn, ppn: tlb_wr_ppn,
                       rights: tlb_wr_rights, dirty: tlb_wr_dirty, refd: tlb_wr_ref};

  lku_xlat_buf #(.N(TLB_ENTRIES), .IW(TIW)) u_xlat (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(page_no(req_vaddr)),
    .upd_ref(ref_upd), .upd_dirty(dirty_upd),
    .wr_en(tlb_wr_en), .wr_entry(new_entry),
    .match_any(xl_hit), .match_idx(xl_idx), .match_entry(hit_entry),
    .victim_ptr(rr_ptr)
  );

  lku_line_store u_lines (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(line_index(req_vaddr)),
    .rd_valid(line_valid), .rd_tag(line_tag), .rd_data(line_data),
    .upd_en(line_wr), .upd_idx(line_index(req_vaddr)), .upd_data(req_wdata),
    .fill_en(fill_en), .fill_idx(line_index(fill_paddr)),
    .fill_tag(page_no(fill_paddr)), .fill_data(fill_data)
  );

  lku_decide u_dec (
    .req_valid(req_valid), .req_write(req_write),
    .xl_hit(xl_hit), .xl_rights(hit_entry.rights), .xl_ppn(hit_entry.ppn),
    .line_valid(line_valid), .line_tag(line_tag),
    .hit_o(rsp_hit), .miss_o(tlb_miss), .fault_o(prot_fault), .mem_o(mem_req),
    .line_wr_o(line_wr), .ref_upd_o(ref_upd), .dirty_upd_o(dirty_upd)
  );

  logic show;
  assign show        = req_valid && xl_hit;
  assign rsp_data    = rsp_hit ? line_data : '0;
  assign tlb_hit_idx = show ? xl_idx : '0;
  assign ent_ref     = show && hit_entry.refd;
  assign ent_dirty   = show && hit_entry.dirty;
  assign mem_we      = req_write;
  assign mem_paddr   = phys_addr(hit_entry.ppn, req_vaddr);
  assign mem_wdata   = req_wdata;
endmodule

// File: rtl/lku_checker.sv
module lku_checker #(parameter int TIW = 3) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_write,
  input logic [31:0]    req_vaddr,
  input logic           rsp_hit,
  input logic           tlb_miss,
  input logic           prot_fault,
  input logic           mem_req,
  input logic           mem_we,
  input logic [31:0]    mem_paddr,
  input logic           line_wr,
  input logic           tlb_wr_en,
  input logic [TIW-1:0] rr_ptr
);
  a_r4_miss_stays_local: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_miss |-> (!mem_req && !rsp_hit));
  a_r6_fault_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> (!mem_req && !rsp_hit && !line_wr));
  a_r3_read_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !req_write) |-> !mem_req);
  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_paddr[11:0] == req_vaddr[11:0]));
  a_r2_outcomes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, tlb_miss, prot_fault}));
  a_r7_store_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !tlb_miss && !prot_fault) |-> (mem_req && mem_we));
  a_r9_pointer_moves: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_en |=> (rr_ptr != $past(rr_ptr)));
endmodule

bind vtlb_cache_lookup lku_checker #(.TIW(TIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_vaddr(req_vaddr), .rsp_hit(rsp_hit), .tlb_miss(tlb_miss),
  .prot_fault(prot_fault), .mem_req(mem_req), .mem_we(mem_we),
  .mem_paddr(mem_paddr), .line_wr(line_wr), .tlb_wr_en(tlb_wr_en),
  .rr_ptr(rr_ptr)
);

// File: tb/vtlb_cache_lookup_test.sv
module vtlb_cache_lookup_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_vaddr = '0, req_wdata = '0;
  logic tlb_wr_en = 0;
  logic [19:0] tlb_wr_vpn = '0, tlb_wr_ppn = '0;
  logic [1:0] tlb_wr_rights = '0;
  logic tlb_wr_dirty = 0, tlb_wr_ref = 0;
  logic fill_en = 0;
  logic [31:0] fill_paddr = '0, fill_data = '0;
  logic rsp_hit, tlb_miss, prot_fault, ent_ref, ent_dirty, mem_req, mem_we;
  logic [31:0] rsp_data, mem_paddr, mem_wdata;
  logic [2:0] tlb_hit_idx;

  int total = 0, bad = 0, refills = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vtlb_cache_lookup uut (.*);

  // Snapshot of outputs taken in the lookup cycle
  logic s_hit, s_miss, s_fault, s_ref, s_dirty, s_mreq, s_mwe;
  logic [31:0] s_data, s_paddr, s_wdata;
  logic [2:0] s_idx;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [1:0] rights);
    @(negedge clk);
    tlb_wr_en = 1; tlb_wr_vpn = vpn; tlb_wr_ppn = ppn; tlb_wr_rights = rights;
    tlb_wr_dirty = 0; tlb_wr_ref = 0;
    @(negedge clk);
    tlb_wr_en = 0;
    refills++;
  endtask

  task automatic fill(input logic [31:0] pa, input logic [31:0] d);
    @(negedge clk);
    fill_en = 1; fill_paddr = pa; fill_data = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic lookup(input logic wr, input logic [31:0] va, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_vaddr = va; req_wdata = wd;
    #2;
    s_hit = rsp_hit; s_miss = tlb_miss; s_fault = prot_fault; s_ref = ent_ref;
    s_dirty = ent_dirty; s_mreq = mem_req; s_mwe = mem_we; s_data = rsp_data;
    s_paddr = mem_paddr; s_wdata = mem_wdata; s_idx = tlb_hit_idx;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic t_reset_state();
    lookup(0, 32'h1234_5344, '0);
    chk("R1", "miss after reset", s_miss, 1);
    chk("R4", "no mem on miss", s_mreq, 0);
    chk("R4", "no hit on miss", s_hit, 0);
  endtask

  task automatic t_first_refill_and_miss();
    refill(20'h12345, 20'hABCDE, 2'b11);
    lookup(0, 32'h1234_5344, '0);
    chk("R1", "translation found", s_miss, 0);
    chk("R9", "first slot", s_idx, 0);
    chk("R1", "line invalid after reset", s_hit, 0);
    chk("R5", "mem read", {s_mreq, s_mwe}, 2'b10);
    chk("R5", "paddr", s_paddr, 32'hABCD_E344);
    chk("R8", "ref starts clear", s_ref, 0);
  endtask

  task automatic t_fill_then_hit();
    fill(32'hABCD_E344, 32'hCAFE_F00D);
    lookup(0, 32'h1234_5344, '0);
    chk("R11", "filled line hits", s_hit, 1);
    chk("R3", "hit data", s_data, 32'hCAFE_F00D);
    chk("R3", "no mem on hit", s_mreq, 0);
    chk("R8", "ref set by earlier access", s_ref, 1);
  endtask

  task automatic t_index_bounds();
    fill(32'hABCD_E000, 32'h1111_0000);
    fill(32'hABCD_EFFC, 32'h2222_FFFF);
    lookup(0, 32'h1234_5000, '0);
    chk("R2", "index 0 data", s_data, 32'h1111_0000);
    lookup(0, 32'h1234_5FFF, '0);
    chk("R2", "index 1023 data via byte 3", s_data, 32'h2222_FFFF);
    chk("R2", "index 1023 hit", s_hit, 1);
    lookup(0, 32'h1234_5344, '0);
    chk("R2", "middle line untouched", s_data, 32'hCAFE_F00D);
  endtask

  task automatic t_tag_mismatch();
    fill(32'h1111_1344, 32'h0000_DEAD);
    lookup(0, 32'h1234_5344, '0);
    chk("R5", "foreign tag misses", s_hit, 0);
    chk("R5", "mem read on mismatch", s_mreq, 1);
    chk("R5", "paddr on mismatch", s_paddr, 32'hABCD_E344);
    fill(32'hABCD_E344, 32'hCAFE_F00D);
  endtask

  task automatic t_write_through();
    lookup(1, 32'h1234_5344, 32'h5A5A_5A5A);
    chk("R7", "store mem req", {s_mreq, s_mwe}, 2'b11);
    chk("R7", "store paddr", s_paddr, 32'hABCD_E344);
    chk("R7", "store data", s_wdata, 32'h5A5A_5A5A);
    chk("R8", "dirty clear before store", s_dirty, 0);
    lookup(0, 32'h1234_5344, '0);
    chk("R7", "cached word updated", s_data, 32'h5A5A_5A5A);
    chk("R8", "dirty after store", s_dirty, 1);
    lookup(1, 32'h1234_5800, 32'h7777_7777);
    chk("R7", "store miss goes out", {s_mreq, s_mwe, s_hit}, 3'b110);
    lookup(0, 32'h1234_5800, '0);
    chk("R7", "no allocate on store miss", {s_hit, s_mreq}, 2'b01);
  endtask

  task automatic t_protection();
    refill(20'h00055, 20'h00777, 2'b01);
    fill(32'h0077_7010, 32'h0BAD_BEEF);
    lookup(1, 32'h0005_5010, 32'h0000_0099);
    chk("R6", "write fault", s_fault, 1);
    chk("R6", "no mem on fault", {s_mreq, s_hit}, 2'b00);
    lookup(0, 32'h0005_5010, '0);
    chk("R6", "word intact", s_data, 32'h0BAD_BEEF);
    chk("R6", "dirty not set by fault", s_dirty, 0);
    chk("R6", "ref not set by fault", s_ref, 0);
    refill(20'h00066, 20'h00888, 2'b10);
    lookup(0, 32'h0006_6000, '0);
    chk("R6", "read fault", {s_fault, s_mreq}, 2'b10);
    lookup(1, 32'h0006_6000, 32'h1);
    chk("R6", "ref untouched by read fault", s_ref, 0);
    chk("R6", "write allowed", s_mreq, 1);
  endtask

  task automatic t_duplicates();
    refill(20'h00099, 20'h00AAA, 2'b11);
    refill(20'h00099, 20'h00BBB, 2'b11);
    lookup(0, 32'h0009_9123, '0);
    chk("R10", "lowest slot", s_idx, 3);
    chk("R10", "lowest slot paddr", s_paddr, 32'h00AA_A123);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 3; k++) refill(20'h00100 + 20'(k), 20'h00500 + 20'(k), 2'b11);
    refill(20'h00200, 20'h00CCC, 2'b11);
    lookup(0, 32'h1234_5344, '0);
    chk("R9", "slot 0 replaced", s_miss, 1);
    lookup(0, 32'h0020_0000, '0);
    chk("R9", "wrapped into slot 0", s_idx, 0);
    chk("R9", "fresh entry ref clear", s_ref, 0);
    lookup(0, 32'h0010_2000, '0);
    chk("R9", "last slot", s_idx, 7);
    refill(20'h00300, 20'h00DDD, 2'b11);
    lookup(0, 32'h0005_5010, '0);
    chk("R9", "slot 1 replaced next", s_miss, 1);
    lookup(0, 32'h0030_0000, '0);
    chk("R9", "new slot 1", s_idx, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_first_refill_and_miss();
    t_fill_then_hit();
    t_index_bounds();
    t_tag_mismatch();
    t_write_through();
    t_protection();
    t_duplicates();
    t_wrap();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule